// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block sits between the MAC-side transmit enable and the 10BASE-T transmit path. It measures each transmission in bit-time ticks. When a single transmission runs past the jabber limit, the block locks out the transmitter and the loopback path. It releases the lockout by itself once the transmit request has stayed quiet for the unjabber interval. A configuration input turns the jabber function off completely.

A second function, off by default, produces a signal-quality-error heartbeat. A short pulse appears on the collision output a fixed number of bit times after every packet ends, so that the MAC can confirm that the collision path works. Bit time is set by an external tick strobe, so the same logic serves any ratio between the system clock and the line rate.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset, `jabber` is 0, `col_out` is 0, `lpbk_en` is 1 and `tx_en_out` is 0 while `mac_tx_en` is low.
- R2: While `jabber` is 0, `tx_en_out` follows `mac_tx_en` in the same cycle and `lpbk_en` is 1.
- R3: `jabber` rises on the clock edge after the JAB_LIMIT-th `bit_tick` sampled during one continuous high period of `mac_tx_en`. Cycles without `bit_tick` do not count, and a low cycle of `mac_tx_en` restarts the count.
- R4: While `jabber` is 1, `tx_en_out` and `lpbk_en` are both 0, whatever the value of `mac_tx_en`.
- R5: The unjabber wait begins on the first edge that samples `mac_tx_en` low while locked. `jabber` clears after UNJAB_LIMIT further `bit_tick`s with `mac_tx_en` held low, which is 1+UNJAB_LIMIT edges when a tick comes every cycle.
- R6: If `mac_tx_en` rises during the unjabber wait, the block stays in jabber and the wait starts again from zero after the next release.
- R7: With `cfg_jab_off` at 1, `jabber` never rises however long the transmission lasts. Setting it during a lockout clears `jabber` on the next edge.
- R8: With `cfg_hb_on` at 0 (the default use), `col_out` stays 0 after packets.
- R9: With `cfg_hb_on` at 1, the edge that samples `mac_tx_en` falling starts a heartbeat. `col_out` goes high HB_DELAY ticks later and stays high for HB_LEN ticks. With one tick per cycle and the defaults 1 and 10, it is high on edges 2 to 11 after the fall.
- R10: A new rise of `mac_tx_en` cancels a pending or running heartbeat, and `col_out` is 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle strobe per line bit time |
| mac_tx_en | input | 1 | Transmit request from the MAC side |
| cfg_jab_off | input | 1 | 1 disables the jabber function |
| cfg_hb_on | input | 1 | 1 enables the heartbeat pulse |
| tx_en_out | output | 1 | Gated transmit enable toward the line |
| lpbk_en | output | 1 | Loopback path permitted |
| jabber | output | 1 | Jabber lockout active |
| col_out | output | 1 | Collision output carrying the heartbeat |

## Verification
A jabber counter that is stuck or misloaded shows at `tx_en_out` as a lockout one or more edges away from the JAB_LIMIT-th tick. The same fault in the unjabber wait shows as `jabber` clearing early or late by the same margin. The bench therefore checks both sides of each boundary edge. A heartbeat state machine that starts in the wrong state or uses the wrong count shows at `col_out` as a pulse that is shifted, too long, missing or not cancelled. This is visible within about a dozen edges of the packet end, so the bench counts the high edges in a window around each pulse.

// File: rtl/txg_pkg.sv
package txg_pkg;

  typedef enum logic [1:0] {
    JS_RUN      = 2'd0,
    JS_LOCK_TX  = 2'd1,
    JS_LOCK_REL = 2'd2
  } jab_state_e;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_WAIT  = 2'd1,
    HS_PULSE = 2'd2
  } hb_state_e;

endpackage

// File: rtl/txg_rst_sync.sv
module txg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/txg_jabber_fsm.sv
module txg_jabber_fsm
  import txg_pkg::*;
#(
  parameter int JAB_LIMIT   = 200000,
  parameter int UNJAB_LIMIT = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic tx_en_i,
  input  logic cfg_off_i,
  output logic jab_o
);

  localparam int MAXL = (JAB_LIMIT > UNJAB_LIMIT) ? JAB_LIMIT : UNJAB_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] JAB_LAST = CW'(JAB_LIMIT - 1);
  localparam logic [CW-1:0] UNJ_LAST = CW'(UNJAB_LIMIT - 1);
  localparam logic [CW-1:0] MAX_LAST = CW'(MAXL - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  jab_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (cfg_off_i) begin
      state_d = JS_RUN;
      cnt_d   = '0;
    end else begin
      case (state_q)
        JS_RUN: begin
          if (!tx_en_i) begin
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_q == JAB_LAST) begin
              state_d = JS_LOCK_TX;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        JS_LOCK_TX: begin
          if (!tx_en_i) begin
            state_d = JS_LOCK_REL;
            cnt_d   = '0;
          end
        end
        JS_LOCK_REL: begin
          if (tx_en_i) begin
            state_d = JS_LOCK_TX;
            cnt_d   = '0;
          end else if (tick_i) begin
            if (cnt_q == UNJ_LAST) begin
              state_d = JS_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        default: begin
          state_d = JS_RUN;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= JS_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign jab_o = (state_q != JS_RUN);

  // R3: lockout is entered only on a tick taken while transmitting
  a_r3_entry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_o) |-> ($past(tx_en_i) && $past(tick_i)));

  // R3: the shared counter never passes the larger limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_LAST);

  // R5: lockout ends only while transmit is released, or through disable
  a_r5_exit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_o) |-> (!$past(tx_en_i) || $past(cfg_off_i)));

  // R7: the disable input forces the unlocked state on the next edge
  a_r7_off_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_off_i |=> !jab_o);

endmodule

// File: rtl/txg_heartbeat.sv
module txg_heartbeat
  import txg_pkg::*;
#(
  parameter int HB_DELAY = 1,
  parameter int HB_LEN   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic tx_en_i,
  input  logic hb_en_i,
  output logic col_o
);

  localparam int  HMAX   = (HB_DELAY > HB_LEN) ? HB_DELAY : HB_LEN;
  localparam int  HCW    = $clog2(HMAX + 1);
  localparam bit  NO_DLY = (HB_DELAY == 0);
  localparam logic [HCW-1:0] DLY_LAST = NO_DLY ? '0 : HCW'(HB_DELAY - 1);
  localparam logic [HCW-1:0] LEN_LAST = HCW'(HB_LEN - 1);
  localparam logic [HCW-1:0] ONE      = HCW'(1);
  localparam hb_state_e START_ST = NO_DLY ? HS_PULSE : HS_WAIT;

  hb_state_e state_q, state_d;
  logic [HCW-1:0] cnt_q, cnt_d;
  logic tx_q;
  logic fall;

  assign fall = tx_q && !tx_en_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      HS_IDLE: begin
        if (fall && hb_en_i) begin
          state_d = START_ST;
          cnt_d   = '0;
        end
      end
      HS_WAIT: begin
        if (tx_en_i) begin
          state_d = HS_IDLE;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == DLY_LAST) begin
            state_d = HS_PULSE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      HS_PULSE: begin
        if (tx_en_i) begin
          state_d = HS_IDLE;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == LEN_LAST) begin
            state_d = HS_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      default: begin
        state_d = HS_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_en_i;
    end
  end

  assign col_o = (state_q == HS_PULSE);

  // R9: the pulse begins on a tick with transmit released
  a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_o) |-> (($past(tick_i) || NO_DLY) && !$past(tx_en_i)));

  // R10: a transmit request removes the pulse on the next edge
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i |=> !col_o);

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int JAB_LIMIT   = 200000,
  parameter int UNJAB_LIMIT = 5000000,
  parameter int HB_DELAY    = 1,
  parameter int HB_LEN      = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic mac_tx_en,
  input  logic cfg_jab_off,
  input  logic cfg_hb_on,
  output logic tx_en_out,
  output logic lpbk_en,
  output logic jabber,
  output logic col_out
);

  logic rst_sync_n;
  logic jab_s;
  logic col_s;

  txg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txg_jabber_fsm #(
    .JAB_LIMIT   (JAB_LIMIT),
    .UNJAB_LIMIT (UNJAB_LIMIT)
  ) u_jab (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (bit_tick),
    .tx_en_i   (mac_tx_en),
    .cfg_off_i (cfg_jab_off),
    .jab_o     (jab_s)
  );

  txg_heartbeat #(
    .HB_DELAY (HB_DELAY),
    .HB_LEN   (HB_LEN)
  ) u_hb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (bit_tick),
    .tx_en_i (mac_tx_en),
    .hb_en_i (cfg_hb_on),
    .col_o   (col_s)
  );

  assign jabber    = jab_s;
  assign tx_en_out = mac_tx_en && !jab_s;
  assign lpbk_en   = !jab_s;
  assign col_out   = col_s;

endmodule

// File: tb/tx_jabber_guard_bench.sv
`timescale 1ns/1ps
module tx_jabber_guard_bench;

  localparam int JL = 20;
  localparam int UL = 30;
  localparam int HD = 1;
  localparam int HL = 10;

  logic clk = 1'b0;
  logic rst_n, bit_tick, mac_tx_en, cfg_jab_off, cfg_hb_on;
  logic tx_en_out, lpbk_en, jabber, col_out;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tx_jabber_guard #(
    .JAB_LIMIT(JL), .UNJAB_LIMIT(UL), .HB_DELAY(HD), .HB_LEN(HL)
  ) u_tx_jabber_guard (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mac_tx_en(mac_tx_en),
    .cfg_jab_off(cfg_jab_off), .cfg_hb_on(cfg_hb_on),
    .tx_en_out(tx_en_out), .lpbk_en(lpbk_en), .jabber(jabber), .col_out(col_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_tick = 1'b1; mac_tx_en = 1'b0;
    cfg_jab_off = 1'b0; cfg_hb_on = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    check("R1 jabber", int'(jabber), 0);
    check("R1 col_out", int'(col_out), 0);
    check("R1 lpbk_en", int'(lpbk_en), 1);
    check("R1 tx_en_out", int'(tx_en_out), 0);
  endtask

  task automatic t_pass();
    mac_tx_en = 1'b1; #1;
    check("R2 tx follows high", int'(tx_en_out), 1);
    check("R2 lpbk_en", int'(lpbk_en), 1);
    step(1);
    mac_tx_en = 1'b0; #1;
    check("R2 tx follows low", int'(tx_en_out), 0);
    step(1);
  endtask

  task automatic t_lock_unlock();
    bit_tick = 1'b0; mac_tx_en = 1'b1;
    step(50);
    check("R3 no tick no count", int'(jabber), 0);
    bit_tick = 1'b1;
    step(JL - 1);
    check("R3 one tick short", int'(jabber), 0);
    step(1);
    check("R3 jabber at limit", int'(jabber), 1);
    check("R4 tx blocked", int'(tx_en_out), 0);
    check("R4 loopback blocked", int'(lpbk_en), 0);
    mac_tx_en = 1'b0;
    step(UL);
    check("R5 still locked", int'(jabber), 1);
    step(1);
    check("R5 released", int'(jabber), 0);
  endtask

  task automatic t_restart();
    mac_tx_en = 1'b1; step(15);
    mac_tx_en = 1'b0; step(1);
    mac_tx_en = 1'b1; step(15);
    check("R3 count restarted", int'(jabber), 0);
    step(5);
    check("R3 limit after restart", int'(jabber), 1);
    mac_tx_en = 1'b0; step(UL + 1);
    check("R5 clear after restart test", int'(jabber), 0);
  endtask

  task automatic t_relock();
    mac_tx_en = 1'b1; step(JL);
    mac_tx_en = 1'b0; step(10);
    mac_tx_en = 1'b1; step(5);
    check("R6 locked on new tx", int'(jabber), 1);
    check("R6 tx blocked", int'(tx_en_out), 0);
    mac_tx_en = 1'b0; step(UL);
    check("R6 wait restarted", int'(jabber), 1);
    step(1);
    check("R6 released", int'(jabber), 0);
  endtask

  task automatic t_jab_off();
    cfg_jab_off = 1'b1; mac_tx_en = 1'b1;
    step(3 * JL);
    check("R7 no jabber when off", int'(jabber), 0);
    check("R7 tx passes when off", int'(tx_en_out), 1);
    cfg_jab_off = 1'b0; mac_tx_en = 1'b0; step(1);
    mac_tx_en = 1'b1; step(JL);
    check("R7 locked again", int'(jabber), 1);
    cfg_jab_off = 1'b1; step(1);
    check("R7 off clears lock", int'(jabber), 0);
    check("R7 tx restored", int'(tx_en_out), 1);
    mac_tx_en = 1'b0; step(1);
    cfg_jab_off = 1'b0; step(2);
  endtask

  task automatic t_hb_off();
    int highs = 0;
    cfg_hb_on = 1'b0;
    mac_tx_en = 1'b1; step(5);
    mac_tx_en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (col_out) highs++;
    end
    check("R8 no heartbeat when disabled", highs, 0);
  endtask

  task automatic t_hb_pulse();
    int highs = 0;
    cfg_hb_on = 1'b1;
    mac_tx_en = 1'b1; step(5);
    mac_tx_en = 1'b0;
    step(1);
    check("R9 low during delay", int'(col_out), 0);
    step(1);
    check("R9 high after delay", int'(col_out), 1);
    highs = 1;
    for (int i = 0; i < 9; i++) begin
      step(1);
      if (col_out) highs++;
    end
    check("R9 pulse length", highs, HL);
    step(1);
    check("R9 low after pulse", int'(col_out), 0);
  endtask

  task automatic t_hb_cancel();
    cfg_hb_on = 1'b1;
    mac_tx_en = 1'b1; step(5);
    mac_tx_en = 1'b0; step(4);
    check("R10 pulse running", int'(col_out), 1);
    mac_tx_en = 1'b1; step(1);
    check("R10 cancelled by tx", int'(col_out), 0);
    check("R10 tx passes", int'(tx_en_out), 1);
    mac_tx_en = 1'b0; step(15);
    cfg_hb_on = 1'b0; step(1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_lock_unlock();
    t_restart();
    t_relock();
    t_jab_off();
    t_hb_off();
    t_hb_pulse();
    t_hb_cancel();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule